// File: doc/BRIEF.md
# Cascadable Serial Configuration Bit Store

This block is the read side of a serial configuration memory. Its contents are a fixed bit array computed at elaboration. Each rising edge of the clock advances a bit pointer, and the bit at that pointer appears on a data output that can be switched off. A loading device drives the clock, pulls chip enable low and then collects the bits one by one.

Several instances can be chained into one stream. Each instance drives its active-low cascade output low once its last bit has gone out, and at the same moment it stops driving data. The next instance takes that cascade output as its chip enable and begins at its own bit 0. A combined reset/output-enable input clears the pointer so that a later readout starts again from the beginning. The active level of that input is set by a polarity input. After power-on reset the block holds a ready flag low for a set number of cycles and then releases it. The flag is modelled as a drive enable with a constant low value.

Top module: `cfg_serial_rom`

## Requirements
- R1: While rst_ni is low, data_oe_o is 0, ceo_no is 1 and ready_oe_o is 1.
- R2: After rst_ni rises, ready_oe_o stays 1 through the first POR_CYCLES-1 rising edges and is 0 from edge POR_CYCLES onward. During that interval data_oe_o is 0 and the pointer does not move.
- R3: Stored bit a equals bit 2 of (a*13 + SEED). data_o shows the bit at the pointer, and the pointer rises by one on each rising edge while ce_ni is 0, the reset/OE input is inactive and the power-on interval has ended.
- R4: On the edge after the last bit (address DEPTH-1) has been shown, ceo_no goes to 0 and data_oe_o goes to 0. The pointer then saturates and no further bit is driven until a reset.
- R5: When the ceo_no of one instance feeds the ce_ni of a second, the shared data line carries 2*DEPTH bits in a row with exactly one driver in each cycle.
- R6: While the reset/OE input is active, data_oe_o is 0. On each rising edge in that state the pointer returns to 0 and ceo_no returns to 1, so bit 0 is shown once the input goes inactive.
- R7: The reset/OE input rst_oe_i is active when it equals rst_pol_i: with rst_pol_i=1 it is active high, and with rst_pol_i=0 it is active low.
- R8: While ce_ni is 1, data_oe_o is 0 whatever the reset/OE level is, and the pointer holds. When ce_ni returns to 0 the readout continues from the same bit.
- R9: ready_o is always 0, so the ready pin can only be pulled low or left floating.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock; rising edge advances the pointer |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| ce_ni | input | 1 | Active-low chip enable; high means standby |
| rst_oe_i | input | 1 | Combined pointer reset / output enable |
| rst_pol_i | input | 1 | Level of rst_oe_i that counts as reset (1 = high) |
| data_o | output | 1 | Serial configuration bit |
| data_oe_o | output | 1 | Drive enable of data_o (0 = high impedance) |
| ceo_no | output | 1 | Active-low cascade enable to the next device |
| ready_o | output | 1 | Ready pin drive value (always 0) |
| ready_oe_o | output | 1 | Ready pin drive enable; 1 during power-on interval |

## Verification
The bench builds two instances with DEPTH=12 and POR_CYCLES=5, using seeds 5 and 90, and wires them as a chain. With this small depth the whole 24-bit chained stream can be compared bit by bit against the formula. The saturation at the end and each edge of the power-on interval are also checked directly. The short array leaves room to interrupt the readout in the middle: the bench clears it through the reset/OE input under both polarities and pauses it in standby, and after each of these it checks that the stream resumes at the correct bit.

// File: rtl/cfg_serial_rom_pkg.sv
`timescale 1ns/1ps
package cfg_serial_rom_pkg;
  localparam int unsigned ROM_MUL = 13;

  // content rule: bit 2 of (addr*ROM_MUL + seed)
  function automatic logic rom_bit(int unsigned addr, int unsigned seed);
    int unsigned v;
    v = addr * ROM_MUL + seed;
    return v[2];
  endfunction
endpackage

// File: rtl/cfg_por_timer.sv
`timescale 1ns/1ps
module cfg_por_timer #(
  parameter int unsigned POR_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(POR_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(POR_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign busy_o = (cnt_q != LIM);
endmodule

// File: rtl/cfg_bit_ptr.sv
`timescale 1ns/1ps
module cfg_bit_ptr #(
  parameter int unsigned DEPTH = 48,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [AW-1:0] ptr_o,
  output logic [AW-1:0] ptr_nxt_o,
  output logic          done_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q, ptr_d;
  logic          done_q, done_d;

  always_comb begin
    ptr_d  = ptr_q;
    done_d = done_q;
    if (clr_i) begin
      ptr_d  = '0;
      done_d = 1'b0;
    end else if (adv_i && !done_q) begin
      if (ptr_q == LAST) done_d = 1'b1;  // saturate, hand off
      else               ptr_d  = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      done_q <= done_d;
    end
  end

  assign ptr_o     = ptr_q;
  assign ptr_nxt_o = ptr_d;
  assign done_o    = done_q;
endmodule

// File: rtl/cfg_bit_rom.sv
`timescale 1ns/1ps
module cfg_bit_rom #(
  parameter int unsigned DEPTH = 48,
  parameter int unsigned SEED  = 0,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  output logic          q_o
);
  import cfg_serial_rom_pkg::*;

  function automatic logic [DEPTH-1:0] fill_rom();
    logic [DEPTH-1:0] b;
    for (int unsigned i = 0; i < DEPTH; i++) b[i] = rom_bit(i, SEED);
    return b;
  endfunction

  localparam logic [DEPTH-1:0] CONTENT = fill_rom();

  logic q_q;

  // registered read of the next address, so q_o tracks the pointer register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= CONTENT[0];
    else         q_q <= CONTENT[addr_i];
  end

  assign q_o = q_q;
endmodule

// File: rtl/cfg_serial_rom.sv
`timescale 1ns/1ps
module cfg_serial_rom #(
  parameter int unsigned DEPTH      = 48,
  parameter int unsigned POR_CYCLES = 8,
  parameter int unsigned SEED       = 0,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic rst_oe_i,
  input  logic rst_pol_i,
  output logic data_o,
  output logic data_oe_o,
  output logic ceo_no,
  output logic ready_o,
  output logic ready_oe_o
);
  logic          por_busy;
  logic          rst_act;
  logic          adv;
  logic          done;
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_nxt;

  assign rst_act = (rst_oe_i == rst_pol_i);
  assign adv     = !ce_ni && !rst_act && !por_busy;

  cfg_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_o (por_busy)
  );

  cfg_bit_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (rst_act),
    .adv_i     (adv),
    .ptr_o     (ptr_q),
    .ptr_nxt_o (ptr_nxt),
    .done_o    (done)
  );

  cfg_bit_rom #(.DEPTH(DEPTH), .SEED(SEED)) u_rom (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (ptr_nxt),
    .q_o    (data_o)
  );

  assign data_oe_o  = !ce_ni && !rst_act && !por_busy && !done;
  assign ceo_no     = !done;
  assign ready_o    = 1'b0;
  assign ready_oe_o = por_busy;
endmodule

// File: rtl/cfg_serial_rom_chk.sv
`timescale 1ns/1ps
module cfg_serial_rom_chk #(
  parameter int unsigned DEPTH = 48,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce_ni,
  input logic          rst_oe_i,
  input logic          rst_pol_i,
  input logic          data_oe_o,
  input logic          ceo_no,
  input logic          ready_o,
  input logic          ready_oe_o,
  input logic [AW-1:0] ptr_i
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  logic rst_on;
  assign rst_on = (rst_oe_i == rst_pol_i);

  p_ptr_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_on |=> (ptr_i == '0) && ceo_no);

  p_pol_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_on |-> !data_oe_o);

  p_standby_hiz_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> !data_oe_o);

  p_standby_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni && !rst_on) |=> $stable(ptr_i));

  p_handoff_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_i == LAST && ceo_no && data_oe_o) |=> (!ceo_no && !data_oe_o) || $past(rst_on));

  p_saturate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ceo_no && !rst_on) |=> !ceo_no && (ptr_i == LAST));

  p_ceo_hiz_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ceo_no |-> !data_oe_o);

  p_ready_once_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_oe_o |=> !ready_oe_o);

  p_ready_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_oe_o |-> !data_oe_o && (ptr_i == '0));

  p_ready_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o == 1'b0);
endmodule

bind cfg_serial_rom cfg_serial_rom_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce_ni      (ce_ni),
  .rst_oe_i   (rst_oe_i),
  .rst_pol_i  (rst_pol_i),
  .data_oe_o  (data_oe_o),
  .ceo_no     (ceo_no),
  .ready_o    (ready_o),
  .ready_oe_o (ready_oe_o),
  .ptr_i      (ptr_q)
);

// File: tb/cfg_serial_rom_bench.sv
`timescale 1ns/1ps
module cfg_serial_rom_bench;
  localparam int unsigned D   = 12;
  localparam int unsigned POR = 5;
  localparam int unsigned SA  = 5;
  localparam int unsigned SB  = 90;

  logic clk = 1'b0;
  logic rst_n, ce_n, rst_oe, pol;
  logic d_a, oe_a, ceo_a, rdy_a, rdy_oe_a;
  logic d_b, oe_b, ceo_b, rdy_b, rdy_oe_b;
  int n_chk = 0, n_fail = 0;
  bit fin = 0;

  always #2.5 clk = ~clk;

  cfg_serial_rom #(.DEPTH(D), .POR_CYCLES(POR), .SEED(SA)) u_cfg_serial_rom (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .rst_oe_i(rst_oe), .rst_pol_i(pol),
    .data_o(d_a), .data_oe_o(oe_a), .ceo_no(ceo_a), .ready_o(rdy_a), .ready_oe_o(rdy_oe_a));

  cfg_serial_rom #(.DEPTH(D), .POR_CYCLES(POR), .SEED(SB)) u_cfg_serial_rom_tail (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ceo_a), .rst_oe_i(rst_oe), .rst_pol_i(pol),
    .data_o(d_b), .data_oe_o(oe_b), .ceo_no(ceo_b), .ready_o(rdy_b), .ready_oe_o(rdy_oe_b));

  function automatic logic exp_bit(int unsigned a, int unsigned s);
    return 1'(((a * 13 + s) >> 2) & 1);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    rst_n = 0; ce_n = 0; rst_oe = 0; pol = 1;
    repeat (3) tick();
    chk("R1 data_oe", oe_a, 1'b0);
    chk("R1 ceo_no", ceo_a, 1'b1);
    chk("R1 ready_oe", rdy_oe_a, 1'b1);
    chk("R9 ready_o", rdy_a, 1'b0);
    rst_n = 1;
    for (int k = 1; k <= POR; k++) begin
      tick();
      chk("R2 ready_oe", rdy_oe_a, (k < POR));
      chk("R2 data_oe", oe_a, (k >= POR));
      chk("R9 ready_o", rdy_a | rdy_b, 1'b0);
    end
    chk("R2 ptr frozen bit0", d_a, exp_bit(0, SA));
    // R3 R5: full chained stream
    for (int i = 0; i < 2 * D; i++) begin
      logic exp;
      exp = (i < D) ? exp_bit(i, SA) : exp_bit(i - D, SB);
      chk("R5 single driver", oe_a ^ oe_b, 1'b1);
      chk("R3 R5 stream bit", oe_a ? d_a : d_b, exp);
      tick();
    end
    chk("R4 ceo_a low", ceo_a, 1'b0);
    chk("R4 ceo_b low", ceo_b, 1'b0);
    chk("R4 a hiz", oe_a, 1'b0);
    chk("R4 b hiz", oe_b, 1'b0);
    repeat (3) tick();
    chk("R4 saturate a", oe_a | oe_b, 1'b0);
    chk("R4 saturate ceo", ceo_b, 1'b0);
    // R6 R7: active-high reset
    rst_oe = 1; tick();
    chk("R6 ceo back high", ceo_a, 1'b1);
    chk("R6 R7 hiz while active", oe_a, 1'b0);
    chk("R6 tail ceo high", ceo_b, 1'b1);
    rst_oe = 0; #1;
    chk("R6 restart oe", oe_a, 1'b1);
    for (int i = 0; i < 5; i++) begin
      chk("R6 restart bit", d_a, exp_bit(i, SA));
      tick();
    end
    // R8: standby mid-stream
    ce_n = 1; #1;
    chk("R8 standby hiz", oe_a, 1'b0);
    repeat (3) tick();
    chk("R8 standby hiz held", oe_a, 1'b0);
    chk("R8 tail quiet", oe_b, 1'b0);
    ce_n = 0; #1;
    chk("R8 resume oe", oe_a, 1'b1);
    chk("R8 resume bit5", d_a, exp_bit(5, SA));
    tick();
    chk("R8 next bit6", d_a, exp_bit(6, SA));
    // R7: active-low polarity, rst_oe=0 now means reset
    pol = 0; #1;
    chk("R7 low-active gates oe", oe_a, 1'b0);
    tick();
    rst_oe = 1; #1;
    chk("R7 oe with rst_oe high", oe_a, 1'b1);
    for (int i = 0; i < 4; i++) begin
      chk("R7 restart bit", d_a, exp_bit(i, SA));
      tick();
    end
    fin = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule